// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives a single DRAM bank. A client presents read or write requests, each with a row and a column address, over a valid/ready handshake. The sequencer keeps a record of whether a row is held in the row buffer and which row it is. It then emits the shortest legal command series for each request. A request to the row that is already open gets just a column command. A request to an idle bank first gets an ACTIVATE. A request to some other row first closes the open row with PRECHARGE, then activates the new one. Activate-to-activate spacing, activate-to-column delay and write-to-read turnaround are each enforced by a down-counter.

After every column command the sequencer waits for a strobe from the data path, which reports that the burst has finished. Under the open-row policy the row is then left open. Under the closed-row policy a PRECHARGE follows at once, unless the request carried a hint that a queued request targets the same row. The policy select is a static input that may change only between requests.

Top module: `dram_bank_seq`

## Requirements
- R1: Out of reset the bank has no open row (`row_open` = 0), no command is issued, and with `req_valid` low `req_ready` is 1.
- R2: A request to a bank with no open row is accepted at once if at least T_RC cycles have passed since the last ACTIVATE. Its ACTIVATE appears the cycle after acceptance, and its column command follows exactly T_RCD cycles after the ACTIVATE, or later if R6 holds it back.
- R3: A request to the open row issues only a column command. That command appears in the cycle after acceptance, with no ACTIVATE and no PRECHARGE.
- R4: A request to a different row while a row is open is accepted at once. A PRECHARGE carrying the old row appears the cycle after acceptance. ACTIVATE of the new row comes next, then the column command after T_RCD cycles.
- R5: Two ACTIVATE commands are at least T_RC cycles apart (default 10). A delayed ACTIVATE issues in exactly the first cycle allowed.
- R6: A READ is at least T_WTR cycles (default 4) after the last WRITE. A read hit waits with `req_ready` low until that is satisfied.
- R7: With `policy_closed` = 1, a PRECHARGE of the open row appears the cycle after `burst_done`, unless `req_same_row` was 1 when the request was accepted. In that case no command follows and the row stays open.
- R8: With `policy_closed` = 0, no command follows `burst_done` and the row stays open. `row_open` and `open_row` always report the row-buffer state.
- R9: `req_ready` is 0 from acceptance until the `burst_done` cycle. It is also 0 while a counter blocks the first command a request needs. Command codes on `cmd_type` are ACTIVATE=0, READ=1, WRITE=2, PRECHARGE=3. `cmd_row` carries the row for ACTIVATE, READ, WRITE and PRECHARGE, with `cmd_col` = 0 on ACTIVATE and PRECHARGE, and `cmd_bank` = BANK_ID (default 0).
- R10: `policy_closed` changes only while the bank is idle, and a change applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_closed | input | 1 | 1 = close row after each access, 0 = keep row open |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_row | input | ROW_W | Request row address |
| req_col | input | COL_W | Request column address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_same_row | input | 1 | Hint: a queued request needs the same row |
| burst_done | input | 1 | Data burst of the last column command is complete |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_type | output | 2 | Command code (see R9) |
| cmd_bank | output | BANK_W | Bank address |
| cmd_row | output | ROW_W | Row field |
| cmd_col | output | COL_W | Column field |
| row_open | output | 1 | A row is held in the row buffer |
| open_row | output | ROW_W | Row held in the row buffer |

## Verification
The first command of a request registers on the acceptance edge, so it is due in the cycle right after `req_ready` and `req_valid` are both high. Each later command is due at the maximum of its predecessor plus one, the last ACTIVATE plus T_RC, the ACTIVATE plus T_RCD, and, for a READ, the last WRITE plus T_WTR. The closing PRECHARGE is due one cycle after `burst_done`. The bench computes each of these edge numbers from its own row-buffer model. At every falling edge between acceptance and the column command it checks that the output holds exactly the expected command or nothing. It also checks that acceptance itself falls on the predicted edge.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_BURST
  } st_e;
endpackage

// File: rtl/dbs_downcnt.sv
module dbs_downcnt #(
  parameter int unsigned SPAN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);
  localparam int unsigned W = $clog2(SPAN + 1);

  logic [W-1:0] cnt;

  // loaded with SPAN-1 on the command edge: the next command may follow SPAN cycles later
  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= W'(SPAN - 1);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dbs_row_track.sv
module dbs_row_track #(
  parameter int unsigned ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_set,
  input  logic             close_clr,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             is_open,
  output logic [ROW_W-1:0] cur_row,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      cur_row <= '0;
    end else if (open_set) begin
      is_open <= 1'b1;
      cur_row <= set_row;
    end else if (close_clr) begin
      is_open <= 1'b0;
    end
  end

  assign hit = is_open && (cur_row == cmp_row);

  AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(open_set && close_clr)); // R4
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dbs_pkg::*;
#(
  parameter int unsigned ROW_W   = 14,
  parameter int unsigned COL_W   = 10,
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned BANK_ID = 0,
  parameter int unsigned T_RC    = 10,
  parameter int unsigned T_WTR   = 4,
  parameter int unsigned T_RCD   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              policy_closed,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic              req_same_row,
  input  logic              burst_done,
  output logic              cmd_valid,
  output logic [1:0]        cmd_type,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              row_open,
  output logic [ROW_W-1:0]  open_row
);
  localparam int unsigned AGE_W = $clog2(T_RC + T_RCD + T_WTR + 1) + 1;

  st_e              st, st_n;
  logic [ROW_W-1:0] q_row;
  logic [COL_W-1:0] q_col;
  logic             q_wr, q_same;

  logic             rc_zero, rcd_zero, wtr_zero;
  logic             is_open, hit;
  logic [ROW_W-1:0] cur_row;

  logic             go;
  cmd_e             go_type;
  logic [ROW_W-1:0] go_row;
  logic [COL_W-1:0] go_col;
  logic             accept;

  assign accept = req_valid && req_ready;

  dbs_downcnt #(.SPAN(T_RC)) u_rc_cnt (
    .clk(clk), .rst(rst), .load(go && go_type == CMD_ACT), .zero(rc_zero));

  dbs_downcnt #(.SPAN(T_RCD)) u_rcd_cnt (
    .clk(clk), .rst(rst), .load(go && go_type == CMD_ACT), .zero(rcd_zero));

  dbs_downcnt #(.SPAN(T_WTR)) u_wtr_cnt (
    .clk(clk), .rst(rst), .load(go && go_type == CMD_WR), .zero(wtr_zero));

  dbs_row_track #(.ROW_W(ROW_W)) u_track (
    .clk(clk), .rst(rst),
    .open_set(go && go_type == CMD_ACT),
    .close_clr(go && go_type == CMD_PRE),
    .set_row(go_row), .cmp_row(req_row),
    .is_open(is_open), .cur_row(cur_row), .hit(hit));

  // next-command selection
  always_comb begin
    go        = 1'b0;
    go_type   = CMD_ACT;
    go_row    = q_row;
    go_col    = q_col;
    st_n      = st;
    req_ready = 1'b0;
    case (st)
      ST_IDLE: begin
        if (hit)          req_ready = req_write || wtr_zero;
        else if (is_open) req_ready = 1'b1;
        else              req_ready = rc_zero;
        if (accept) begin
          go     = 1'b1;
          go_row = req_row;
          go_col = req_col;
          if (hit) begin
            go_type = req_write ? CMD_WR : CMD_RD;
            st_n    = ST_BURST;
          end else if (is_open) begin
            go_type = CMD_PRE;
            go_row  = cur_row;
            go_col  = '0;
            st_n    = ST_ACT;
          end else begin
            go_type = CMD_ACT;
            go_col  = '0;
            st_n    = ST_RCD;
          end
        end
      end
      ST_ACT: begin
        if (rc_zero) begin
          go      = 1'b1;
          go_type = CMD_ACT;
          go_col  = '0;
          st_n    = ST_RCD;
        end
      end
      ST_RCD: begin
        if (rcd_zero && (q_wr || wtr_zero)) begin
          go      = 1'b1;
          go_type = q_wr ? CMD_WR : CMD_RD;
          st_n    = ST_BURST;
        end
      end
      ST_BURST: begin
        if (burst_done) begin
          st_n = ST_IDLE;
          if (policy_closed && !q_same) begin
            go      = 1'b1;
            go_type = CMD_PRE;
            go_row  = cur_row;
            go_col  = '0;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      q_row     <= '0;
      q_col     <= '0;
      q_wr      <= 1'b0;
      q_same    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_type  <= CMD_ACT;
      cmd_row   <= '0;
      cmd_col   <= '0;
    end else begin
      st        <= st_n;
      cmd_valid <= go;
      cmd_type  <= go_type;
      cmd_row   <= go_row;
      cmd_col   <= go_col;
      if (accept) begin
        q_row  <= req_row;
        q_col  <= req_col;
        q_wr   <= req_write;
        q_same <= req_same_row;
      end
    end
  end

  assign cmd_bank = BANK_W'(BANK_ID);
  assign row_open = is_open;
  assign open_row = cur_row;

  // cycles since the last issued ACTIVATE / WRITE, measured at the outputs
  logic [AGE_W-1:0] act_age, wr_age;
  always_ff @(posedge clk) begin
    if (rst) begin
      act_age <= '1;
      wr_age  <= '1;
    end else begin
      if (cmd_valid && cmd_type == CMD_ACT) act_age <= AGE_W'(1);
      else if (act_age != '1)               act_age <= act_age + 1'b1;
      if (cmd_valid && cmd_type == CMD_WR)  wr_age  <= AGE_W'(1);
      else if (wr_age != '1)                wr_age  <= wr_age + 1'b1;
    end
  end

  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == CMD_ACT) |-> act_age >= AGE_W'(T_RC)); // R5
  AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_type == CMD_RD || cmd_type == CMD_WR)) |-> act_age >= AGE_W'(T_RCD)); // R2
  AST_WR_TO_RD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == CMD_RD) |-> wr_age >= AGE_W'(T_WTR)); // R6
  AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_type == CMD_RD || cmd_type == CMD_WR)) |-> row_open); // R3
  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == CMD_ACT) |-> !$past(is_open)); // R4
  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> cmd_valid); // R9
  AST_POLICY_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> $stable(policy_closed)); // R10
endmodule

// File: tb/dram_bank_seq_bench.sv
`timescale 1ns/1ps
module dram_bank_seq_bench;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int T_RC  = 10;
  localparam int T_WTR = 4;
  localparam int T_RCD = 3;
  localparam logic [1:0] C_ACT = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_PRE = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic policy_closed = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_write = 1'b0;
  logic req_same_row = 1'b0;
  logic burst_done = 1'b0;
  logic cmd_valid;
  logic [1:0] cmd_type;
  logic [2:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic row_open;
  logic [ROW_W-1:0] open_row;

  dram_bank_seq u_dram_bank_seq (
    .clk(clk), .rst(rst), .policy_closed(policy_closed),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
    .req_col(req_col), .req_write(req_write), .req_same_row(req_same_row),
    .burst_done(burst_done), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .row_open(row_open), .open_row(open_row));

  always #2.5 clk = ~clk;

  int edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the row buffer and timing history (edge numbers)
  bit m_open = 1'b0;
  logic [ROW_W-1:0] m_row = '0;
  int last_act = -1000;
  int last_wr = -1000;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk_int(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_cmd(input bit ev, input logic [1:0] et, input logic [ROW_W-1:0] er,
                         input logic [COL_W-1:0] ec, input string tag);
    n_chk++;
    if (ev) begin
      if (!(cmd_valid && cmd_type == et && cmd_row == er && cmd_col == ec && cmd_bank == 3'd0)) begin
        n_fail++;
        $display("FAIL %s at edge %0d: got v=%0b t=%0d r=%0d c=%0d b=%0d expected v=1 t=%0d r=%0d c=%0d b=0",
                 tag, edge_n, cmd_valid, cmd_type, cmd_row, cmd_col, cmd_bank, et, er, ec);
      end
    end else if (cmd_valid) begin
      n_fail++;
      $display("FAIL %s at edge %0d: got command t=%0d expected none", tag, edge_n, cmd_type);
    end
  endtask

  // one request from presentation to the end of its burst; called at a falling edge
  task automatic run_req(input bit pol, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                         input bit wr, input bit hint, input int gap);
    int p, exp_a, acc, e_pre, e_act, e_col, n, d;
    bit is_hit, is_conf;
    string tg;
    logic [1:0] col_t;
    policy_closed = pol;
    req_valid = 1'b1;
    req_row = row;
    req_col = col;
    req_write = wr;
    req_same_row = hint;
    p = edge_n + 1;
    is_hit = m_open && (m_row == row);
    is_conf = m_open && !is_hit;
    col_t = wr ? C_WR : C_RD;
    e_pre = -1;
    e_act = -1;
    if (is_hit) begin
      exp_a = wr ? p : imax(p, last_wr + T_WTR);
      e_col = exp_a;
      tg = wr ? "R3" : "R6";
    end else if (is_conf) begin
      exp_a = p;
      e_pre = p;
      e_act = imax(p + 1, last_act + T_RC);
      e_col = imax(e_act + T_RCD, wr ? 0 : last_wr + T_WTR);
      tg = "R4";
    end else begin
      exp_a = imax(p, last_act + T_RC);
      e_act = exp_a;
      e_col = imax(e_act + T_RCD, wr ? 0 : last_wr + T_WTR);
      tg = "R2";
    end
    #1;
    n = 0;
    while (!req_ready && n < 64) begin
      @(negedge clk);
      #1;
      n++;
    end
    acc = edge_n + 1;
    chk_int(acc, exp_a, {tg, " acceptance edge"});
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk_int(int'(req_ready), 0, "R9 ready low while busy");
    forever begin
      if (edge_n == e_pre)      chk_cmd(1'b1, C_PRE, m_row, '0, "R4 precharge of old row");
      else if (edge_n == e_act) chk_cmd(1'b1, C_ACT, row, '0, is_conf ? "R5 activate" : "R2 activate");
      else if (edge_n == e_col) chk_cmd(1'b1, col_t, row, col, {tg, " column command"});
      else                      chk_cmd(1'b0, C_ACT, '0, '0, {tg, " idle slot"});
      if (edge_n >= e_col) break;
      @(negedge clk);
    end
    if (!is_hit) begin
      last_act = e_act;
      m_open = 1'b1;
      m_row = row;
    end
    if (wr) last_wr = e_col;
    repeat (gap) @(negedge clk);
    burst_done = 1'b1;
    d = edge_n + 1;
    @(negedge clk);
    burst_done = 1'b0;
    #1;
    chk_int(edge_n, d, "R7 burst edge");
    if (pol && !hint) begin
      chk_cmd(1'b1, C_PRE, m_row, '0, "R7 closing precharge");
      m_open = 1'b0;
    end else begin
      chk_cmd(1'b0, C_ACT, '0, '0, pol ? "R7 hint keeps row" : "R8 open policy");
    end
    chk_int(int'(row_open), int'(m_open), "R8 row_open");
    if (m_open) chk_int(int'(open_row), int'(m_row), "R8 open_row");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk_int(int'(cmd_valid), 0, "R1 no command after reset");
    chk_int(int'(row_open), 0, "R1 no open row after reset");
    chk_int(int'(req_ready), 1, "R1 ready after reset");

    // directed corner cases
    run_req(1'b0, 14'd5, 10'd7,  1'b0, 1'b0, 0);   // R2 empty bank
    run_req(1'b0, 14'd5, 10'd8,  1'b0, 1'b0, 0);   // R3 read hit
    run_req(1'b0, 14'd5, 10'd9,  1'b1, 1'b0, 0);   // R3 write hit
    run_req(1'b0, 14'd5, 10'd10, 1'b0, 1'b0, 0);   // R6 read blocked by turnaround
    run_req(1'b0, 14'd9, 10'd1,  1'b0, 1'b0, 0);   // R4 conflict
    run_req(1'b0, 14'd2, 10'd3,  1'b1, 1'b0, 0);   // R5 activate held by spacing
    run_req(1'b1, 14'd2, 10'd4,  1'b0, 1'b1, 1);   // R7 hint keeps row open
    run_req(1'b1, 14'd2, 10'd5,  1'b1, 1'b0, 2);   // R7 closing precharge
    run_req(1'b1, 14'd3, 10'd6,  1'b0, 1'b0, 0);   // R7 closed bank reopened
    run_req(1'b0, 14'd3, 10'd7,  1'b0, 1'b0, 3);   // R10 policy switched while idle
    run_req(1'b0, 14'd3, 10'd8,  1'b0, 1'b0, 0);   // R10 open policy now in force
    chk_int(int'(row_open), 1, "R10 row still open after policy change");

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      run_req(1'($urandom % 2), 14'($urandom % 4), 10'($urandom), 1'($urandom % 2),
              1'($urandom % 2), int'($urandom % 4));
    end
    finish_run();
  end
endmodule